// File: doc/BRIEF.md
# FSK Byte Output Interface

This block sits behind an FSK demodulator and turns its recovered 1200-baud asynchronous bit stream into something a host can consume without a UART. Each character on the line is framed as one low start bit, eight data bits sent least significant bit first, and one high stop bit. A mode input selects how the host sees the characters.

In bit-stream mode (mode input low) the synchronized line value is presented on the data output. A data clock makes one rising edge in the middle of each of the eight data bits and stays low through start and stop bits, so a shift register or a polled port can latch the byte. In buffered mode (mode input high) the data clock stays quiet and the eight data bits plus the stop bit are captured into a 9-bit parallel word. In both modes an active-low ready strobe lasts half a bit time from the start of the stop bit.

Bit timing comes from a 16x oversampling tick divided down from the system clock. A falling edge on the idle-high line starts a character, and the tick phase is realigned to that edge. A start bit that is high again at its midpoint is discarded. Losing the carrier-present flag returns the receiver to idle at once.

Top module: `fsk_byte_port`

## Requirements
- R1: After reset the data clock is 0, the ready strobe is 1 (inactive), the 9-bit buffer is 0 and the data output is 1.
- R2: In bit-stream mode the data output carries the received line value, delayed only by the input synchronizer.
- R3: In bit-stream mode every valid character produces exactly 8 rising edges on the data clock.
- R4: Each data clock rising edge falls at the midpoint of a data bit. The clock stays high until the end of that bit and is low for the whole of the start and stop bits.
- R5: In both modes the ready strobe goes low at the start of the stop bit, once per valid character. It stays low for half a bit time and is never low while the data clock is high.
- R6: In buffered mode, bits [7:0] of the buffer hold the data byte, with the first received data bit in bit 0. Bit [8] holds the sampled stop bit.
- R7: In buffered mode the data clock stays 0 and the data output is held at 1.
- R8: The buffer is not written while the mode input is low.
- R9: A start bit that is high again at its midpoint returns the receiver to idle. It produces no data clock edge and no ready strobe.
- R10: While the carrier flag is low, the receiver is held idle. The data clock is 0, no ready strobe occurs and the buffer is unchanged, including for a character cut off mid-way.
- R11: A stop bit sampled as 0 is stored as 0 in buffer bit [8]. The receiver then waits for the line to go high before it accepts the next start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | 0 = bit-stream mode, 1 = buffered mode |
| rx_bit | input | 1 | Demodulated line bit, idle high |
| carrier_ok | input | 1 | Carrier present flag from the demodulator |
| ser_data | output | 1 | Data line to the host (bit-stream mode) |
| dclk | output | 1 | Gated data clock, 8 pulses per character |
| data_rdy_n | output | 1 | Active-low half-bit ready strobe |
| buf_word | output | 9 | Stop bit in [8], data byte in [7:0] |

## Verification
The hardest case to reach is a carrier drop in the middle of a character. The drop must leave no trace: no late ready strobe, no partial buffer write, and no stray data clock count carried into the next character. The bench starts a buffered-mode character, pulls the carrier flag low at the start of the fifth data bit while the line keeps toggling, and then brings the carrier back with the line idle. It then confirms that the buffer and strobe count are unchanged and that a following full character decodes cleanly. A mid-start glitch shorter than half a bit is used the same way to reach the false-start path.

// File: rtl/fskout_pkg.sv
package fskout_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_START = 2'd1,
      ST_DATA  = 2'd2,
      ST_STOP  = 2'd3
   } rx_state_e;
endpackage

// File: rtl/fskout_sync.sv
module fskout_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] flops;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flops <= '1;
            else        flops <= {flops[STAGES-2+((STAGES==1)?1:0):0], d};
         end
         assign q = flops[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/fskout_tick.sv
module fskout_tick #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   generate
      if (DIV <= 1) begin : g_every
         assign tick = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(DIV);
         localparam logic [CW-1:0] TOP = CW'(DIV - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 cnt <= '0;
            else if (restart || tick)   cnt <= '0;
            else                        cnt <= cnt + 1'b1;
         end
         assign tick = (cnt == TOP) && !restart;
      end
   endgenerate
endmodule

// File: rtl/fskout_rx.sv
module fskout_rx
   import fskout_pkg::*;
#(
   parameter int OVS       = 16,
   parameter int DATA_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rx_s,
   input  logic                 carrier_ok,
   input  logic                 tick,
   output logic                 restart,
   output logic                 dclk_int,
   output logic                 dr_n,
   output logic                 done,
   output logic [DATA_BITS:0]   word
);
   localparam int SCW = $clog2(OVS);
   localparam int BW  = $clog2(DATA_BITS);
   localparam logic [SCW-1:0] MID  = SCW'(OVS / 2 - 1);
   localparam logic [SCW-1:0] LAST = SCW'(OVS - 1);
   localparam logic [BW-1:0]  LAST_BIT = BW'(DATA_BITS - 1);

   rx_state_e              state;
   logic [SCW-1:0]         sc;
   logic [BW-1:0]          bit_idx;
   logic [DATA_BITS-1:0]   shreg;
   logic                   rx_q;
   logic                   fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rx_q <= 1'b1;
      else        rx_q <= rx_s;
   end

   assign fall    = rx_q && !rx_s;
   assign restart = (state == ST_IDLE) && fall && carrier_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         sc       <= '0;
         bit_idx  <= '0;
         shreg    <= '0;
         dclk_int <= 1'b0;
         dr_n     <= 1'b1;
         done     <= 1'b0;
         word     <= '0;
      end else if (!carrier_ok) begin
         state    <= ST_IDLE;
         sc       <= '0;
         dclk_int <= 1'b0;
         dr_n     <= 1'b1;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (fall) begin
                  state <= ST_START;
                  sc    <= '0;
               end
            end
            ST_START: begin
               if (tick) begin
                  sc <= sc + 1'b1;
                  if (sc == MID && rx_s) begin
                     state <= ST_IDLE;
                  end else if (sc == LAST) begin
                     state   <= ST_DATA;
                     sc      <= '0;
                     bit_idx <= '0;
                  end
               end
            end
            ST_DATA: begin
               if (tick) begin
                  sc <= sc + 1'b1;
                  if (sc == MID) begin
                     shreg    <= {rx_s, shreg[DATA_BITS-1:1]};
                     dclk_int <= 1'b1;
                  end
                  if (sc == LAST) begin
                     dclk_int <= 1'b0;
                     sc       <= '0;
                     if (bit_idx == LAST_BIT) begin
                        state <= ST_STOP;
                        dr_n  <= 1'b0;
                     end else begin
                        bit_idx <= bit_idx + 1'b1;
                     end
                  end
               end
            end
            ST_STOP: begin
               if (tick) begin
                  sc <= sc + 1'b1;
                  if (sc == MID) begin
                     dr_n  <= 1'b1;
                     done  <= 1'b1;
                     word  <= {rx_s, shreg};
                     state <= ST_IDLE;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/fsk_byte_port.sv
module fsk_byte_port #(
   parameter int CLK_HZ      = 100_000_000,
   parameter int BAUD        = 1200,
   parameter int OVERSAMPLE  = 16,
   parameter int DATA_BITS   = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mode_sel,
   input  logic                 rx_bit,
   input  logic                 carrier_ok,
   output logic                 ser_data,
   output logic                 dclk,
   output logic                 data_rdy_n,
   output logic [DATA_BITS:0]   buf_word
);
   localparam int TICK_DIV = CLK_HZ / (BAUD * OVERSAMPLE);

   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $error("clock too slow for baud rate and oversampling");
      end
      if (OVERSAMPLE < 4 || (OVERSAMPLE & (OVERSAMPLE - 1)) != 0) begin : g_bad_ovs
         $error("oversampling must be a power of two of at least 4");
      end
      if (DATA_BITS < 2) begin : g_bad_bits
         $error("at least two data bits required");
      end
   endgenerate

   logic                 rx_s;
   logic                 tick;
   logic                 restart;
   logic                 dclk_int;
   logic                 done;
   logic [DATA_BITS:0]   word;

   fskout_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(rx_bit), .q(rx_s)
   );

   fskout_tick #(.DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick)
   );

   fskout_rx #(.OVS(OVERSAMPLE), .DATA_BITS(DATA_BITS)) u_rx (
      .clk(clk), .rst_n(rst_n), .rx_s(rx_s), .carrier_ok(carrier_ok),
      .tick(tick), .restart(restart), .dclk_int(dclk_int),
      .dr_n(data_rdy_n), .done(done), .word(word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                buf_word <= '0;
      else if (done && mode_sel) buf_word <= word;
   end

   assign ser_data = mode_sel ? 1'b1 : rx_s;
   assign dclk     = dclk_int && !mode_sel;
endmodule

// File: rtl/fsk_byte_port_chk.sv
module fsk_byte_port_chk #(
   parameter int OVS   = 16,
   parameter int DIV   = 4,
   parameter int NBITS = 8
) (
   input logic           clk,
   input logic           rst_n,
   input logic           mode_sel,
   input logic           carrier_ok,
   input logic           dclk,
   input logic           data_rdy_n,
   input logic [NBITS:0] buf_word
);
   localparam int LOW_MAX = (OVS / 2) * ((DIV < 1) ? 1 : DIV);

   logic        dclk_q;
   logic        dr_q;
   logic        dr_fell;
   logic [7:0]  rise_cnt;
   logic [31:0] low_cnt;

   assign dr_fell = dr_q && !data_rdy_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dclk_q   <= 1'b0;
         dr_q     <= 1'b1;
         rise_cnt <= '0;
         low_cnt  <= '0;
      end else begin
         dclk_q <= dclk;
         dr_q   <= data_rdy_n;
         if (!carrier_ok || dr_fell)  rise_cnt <= '0;
         else if (dclk && !dclk_q)    rise_cnt <= rise_cnt + 1'b1;
         low_cnt <= data_rdy_n ? '0 : low_cnt + 1;
      end
   end

   p_eight_clocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dr_fell && !mode_sel) |-> (rise_cnt == 8'(NBITS)));

   p_no_extra_clocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rise_cnt <= 8'(NBITS));

   p_ready_half_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      low_cnt <= LOW_MAX);

   p_ready_clock_apart_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !data_rdy_n |-> !dclk);

   p_carrier_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !carrier_ok |=> (!dclk && data_rdy_n));

   p_buf_hold_stream_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!mode_sel) |-> $stable(buf_word));
endmodule

bind fsk_byte_port fsk_byte_port_chk #(
   .OVS(OVERSAMPLE), .DIV(TICK_DIV), .NBITS(DATA_BITS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .carrier_ok(carrier_ok),
   .dclk(dclk), .data_rdy_n(data_rdy_n), .buf_word(buf_word)
);

// File: tb/fsk_byte_port_tb.sv
module fsk_byte_port_tb;
   localparam int OVS  = 16;
   localparam int DIVN = 4;
   localparam int BITC = OVS * DIVN;
   localparam int CLKF = 1200 * OVS * DIVN;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_sel = 1'b0;
   logic       rx_bit = 1'b1;
   logic       carrier_ok = 1'b1;
   logic       ser_data;
   logic       dclk;
   logic       data_rdy_n;
   logic [8:0] buf_word;

   int checks = 0;
   int failures = 0;
   int dclk_rises = 0;
   int dr_falls = 0;
   logic [7:0] host_byte = '0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   fsk_byte_port #(.CLK_HZ(CLKF), .BAUD(1200), .OVERSAMPLE(OVS),
                   .DATA_BITS(8), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .rx_bit(rx_bit),
      .carrier_ok(carrier_ok), .ser_data(ser_data), .dclk(dclk),
      .data_rdy_n(data_rdy_n), .buf_word(buf_word)
   );

   always @(posedge dclk) begin
      dclk_rises <= dclk_rises + 1;
      host_byte  <= {ser_data, host_byte[7:1]};
   end
   always @(negedge data_rdy_n) if (rst_n) dr_falls <= dr_falls + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // One bit period on the line with probes at 1/4 and 3/4 of the bit.
   // kind: 0 start, 1 data, 2 stop
   task automatic line_bit(input logic v, input int kind);
      rx_bit = v;
      wait_n(BITC / 4);
      chk(dclk == 1'b0, "R4 clock low early in bit", dclk, 0);
      if (kind == 2) chk(data_rdy_n == 1'b0, "R5 ready low at stop start", data_rdy_n, 0);
      else           chk(data_rdy_n == 1'b1, "R5 ready idle outside stop", data_rdy_n, 1);
      wait_n(BITC / 2);
      if (kind == 1 && !mode_sel) begin
         chk(dclk == 1'b1, "R4 clock high after mid-bit", dclk, 1);
         chk(ser_data == v, "R2 data output follows line", ser_data, v);
      end else begin
         chk(dclk == 1'b0, "R4/R7 clock low", dclk, 0);
      end
      if (mode_sel) chk(ser_data == 1'b1, "R7 data output held high", ser_data, 1);
      if (kind == 2) chk(data_rdy_n == 1'b1, "R5 ready back high after half bit", data_rdy_n, 1);
      wait_n(BITC - BITC / 4 - BITC / 2);
   endtask

   task automatic send_char(input logic [7:0] b, input logic stop);
      line_bit(1'b0, 0);
      for (int k = 0; k < 8; k++) line_bit(b[k], 1);
      line_bit(stop, 2);
      rx_bit = 1'b1;
      wait_n(BITC);
   endtask

   task automatic t_reset;
      wait_n(3);
      chk(dclk == 1'b0, "R1 reset clock", dclk, 0);
      chk(data_rdy_n == 1'b1, "R1 reset ready", data_rdy_n, 1);
      chk(buf_word == 9'h0, "R1 reset buffer", buf_word, 0);
      chk(ser_data == 1'b1, "R1 reset data", ser_data, 1);
   endtask

   task automatic t_stream(input logic [7:0] b);
      int r0, d0;
      logic [8:0] hold;
      mode_sel = 1'b0; r0 = dclk_rises; d0 = dr_falls; hold = buf_word;
      wait_n(4);
      send_char(b, 1'b1);
      chk(dclk_rises - r0 == 8, "R3 eight clock edges", dclk_rises - r0, 8);
      chk(host_byte == b, "R2/R4 host assembled byte", host_byte, b);
      chk(dr_falls - d0 == 1, "R5 one ready strobe", dr_falls - d0, 1);
      chk(buf_word == hold, "R8 buffer untouched in stream mode", buf_word, hold);
   endtask

   task automatic t_buffered(input logic [7:0] b, input logic stop);
      int r0, d0;
      mode_sel = 1'b1; r0 = dclk_rises; d0 = dr_falls;
      wait_n(4);
      send_char(b, stop);
      chk(dclk_rises - r0 == 0, "R7 no clock in buffered mode", dclk_rises - r0, 0);
      chk(dr_falls - d0 == 1, "R5 ready strobe in buffered mode", dr_falls - d0, 1);
      if (stop) chk(buf_word == {1'b1, b}, "R6 buffer word", buf_word, {1'b1, b});
      else      chk(buf_word == {1'b0, b}, "R11 framing error stop bit stored", buf_word, {1'b0, b});
   endtask

   task automatic t_false_start;
      int r0, d0;
      mode_sel = 1'b0; r0 = dclk_rises; d0 = dr_falls;
      rx_bit = 1'b0; wait_n(BITC / 4);
      rx_bit = 1'b1; wait_n(12 * BITC);
      chk(dclk_rises == r0, "R9 no clock after false start", dclk_rises - r0, 0);
      chk(dr_falls == d0, "R9 no ready after false start", dr_falls - d0, 0);
      t_stream(8'h5A);
   endtask

   task automatic t_carrier;
      int d0;
      logic [8:0] hold;
      mode_sel = 1'b1; d0 = dr_falls; hold = buf_word;
      wait_n(4);
      line_bit(1'b0, 0);
      for (int k = 0; k < 4; k++) line_bit(k[0], 1);
      carrier_ok = 1'b0;
      for (int k = 0; k < 5; k++) begin rx_bit = ~rx_bit; wait_n(BITC); end
      chk(data_rdy_n == 1'b1, "R10 ready idle without carrier", data_rdy_n, 1);
      rx_bit = 1'b1; wait_n(BITC);
      // full character while carrier absent
      rx_bit = 1'b0; wait_n(BITC);
      for (int k = 0; k < 9; k++) begin rx_bit = 1'b1; wait_n(BITC); end
      chk(dr_falls == d0, "R10 no ready strobe without carrier", dr_falls - d0, 0);
      chk(buf_word == hold, "R10 buffer unchanged", buf_word, hold);
      carrier_ok = 1'b1; wait_n(BITC);
      chk(dr_falls == d0, "R10 no late strobe on carrier return", dr_falls - d0, 0);
      t_buffered(8'hC3, 1'b1);
   endtask

   initial begin
      wait_n(5);
      rst_n = 1'b1;
      t_reset();
      t_stream(8'hA5);
      t_stream(8'h00);
      t_stream(8'hFF);
      t_buffered(8'h3C, 1'b1);
      t_buffered(8'h81, 1'b0);
      t_stream(8'h96);
      t_false_start();
      t_carrier();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int i = 0; i < 100000; i++) begin
         @(posedge clk);
         if (finished) break;
      end
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule